// File: doc/BRIEF.md
# Floating-Point Error Report Router

This block decides what happens to an unmasked floating-point error once the arithmetic unit has flagged it. It holds the error as a pending condition. It then hands that condition to one of three destinations. The choice depends on a numeric-error control bit and an ignore input pin.

- **Internal mode.** With the control bit set, the error becomes an internal exception request. The request fires when the next waiting-form floating-point or WAIT instruction is about to issue.
- **Discard mode.** With the control bit clear and the ignore pin high, errors are thrown away and execution is never held.
- **External mode.** With the control bit clear and the ignore pin low, the pending error drives an external error pin meant for an interrupt controller. The next waiting instruction is stalled until software clears the error or the ignore pin is raised.

All inputs and outputs are plain control pins sampled on the rising clock edge. There is no data stream, so no back-pressure applies. Reset is asynchronous and active low.

Top module: `fpe_report_ctrl`

## Requirements
- R1: While reset is active, `exc_req`, `err_pin` and `stall` are all 0, and no error is pending after reset is released.
- R2: A cycle with `err_clear` high and `err_event` low empties the pending error from the next cycle on.
- R3: When `err_event` arrives in the same cycle as a clear or as an internal report, the error is still pending afterwards.
- R4: In internal mode (`ne_bit`=1), a `wait_strobe` while an error is pending raises `exc_req` for exactly one cycle, in the cycle after the strobe. That report consumes the pending error.
- R5: In internal mode, `err_pin` and `stall` stay 0 whatever the state of `ignore_in`.
- R6: In internal mode, a `wait_strobe` while nothing is pending gives no `exc_req` pulse.
- R7: In discard mode (`ne_bit`=0, `ignore_in`=1), error events are dropped, any pending error is discarded, and all three outputs stay 0.
- R8: In external mode (`ne_bit`=0, `ignore_in`=0), `err_pin` is 1 exactly while an error is pending, starting the cycle after the event.
- R9: In external mode, a `wait_strobe` while an error is pending sets `stall` from the next cycle, and `stall` holds while the error stays pending.
- R10: `stall` drops in the cycle after the pending error is cleared.
- R11: `stall` drops in the cycle after `ignore_in` is raised.
- R12: In external mode, a `wait_strobe` with no pending error does not stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ne_bit | input | 1 | 1 selects internal exception reporting |
| ignore_in | input | 1 | Ignore-error pin, used only when `ne_bit` is 0 |
| err_event | input | 1 | Unmasked error flagged by the floating-point unit |
| err_clear | input | 1 | Software clear of the pending error |
| wait_strobe | input | 1 | Next waiting-form floating-point or WAIT instruction is about to issue |
| exc_req | output | 1 | One-cycle internal numeric exception request |
| err_pin | output | 1 | External error pin toward an interrupt controller |
| stall | output | 1 | Holds execution before the waiting instruction |

## Verification
A new error event can land in the same cycle as the action that would empty the pending flag. There are two such collisions:

- **Clear collision.** The event arrives together with a software clear in external mode. The bench judges this by `err_pin` staying high.
- **Report collision.** The event arrives together with a `wait_strobe` that reports in internal mode. The bench judges this by a second `exc_req` pulse on the following strobe.

The event must win in both collisions. The bench drives each collision at a chosen negative edge and compares the outputs one clock later against hand-derived expectations.

// File: rtl/fpe_pkg.sv
package fpe_pkg;
  typedef enum logic [1:0] {
    FPE_INTERNAL = 2'd0,
    FPE_DISCARD  = 2'd1,
    FPE_EXTERNAL = 2'd2
  } fpe_mode_e;
endpackage

// File: rtl/fpe_mode_sel.sv
module fpe_mode_sel
  import fpe_pkg::*;
(
  input  logic      ne_bit,
  input  logic      ignore_in,
  output fpe_mode_e mode
);
  // the control bit dominates; the ignore pin matters only when it is clear
  always_comb begin
    if (ne_bit)         mode = FPE_INTERNAL;
    else if (ignore_in) mode = FPE_DISCARD;
    else                mode = FPE_EXTERNAL;
  end
endmodule

// File: rtl/fpe_pending_flag.sv
module fpe_pending_flag
  import fpe_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  fpe_mode_e mode,
  input  logic      err_event,
  input  logic      err_clear,
  input  logic      consume,
  output logic      pend_q,
  output logic      pend_d
);
  // a fresh event outranks a clear or a report in the same cycle
  always_comb begin
    if (mode == FPE_DISCARD)     pend_d = 1'b0;
    else if (err_event)          pend_d = 1'b1;
    else if (err_clear || consume) pend_d = 1'b0;
    else                         pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/fpe_report_seq.sv
module fpe_report_seq
  import fpe_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  fpe_mode_e mode,
  input  logic      wait_strobe,
  input  logic      pend_q,
  input  logic      pend_d,
  output logic      consume,
  output logic      exc_req,
  output logic      stall
);
  logic ext_mode;
  logic stall_d;

  assign ext_mode = (mode == FPE_EXTERNAL);
  assign consume  = (mode == FPE_INTERNAL) && wait_strobe && pend_q;
  assign stall_d  = ext_mode && pend_d && (stall || (wait_strobe && pend_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_req <= 1'b0;
      stall   <= 1'b0;
    end else begin
      exc_req <= consume;
      stall   <= stall_d;
    end
  end
endmodule

// File: rtl/fpe_report_ctrl.sv
module fpe_report_ctrl
  import fpe_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ne_bit,
  input  logic ignore_in,
  input  logic err_event,
  input  logic err_clear,
  input  logic wait_strobe,
  output logic exc_req,
  output logic err_pin,
  output logic stall
);
  fpe_mode_e mode;
  logic      pend_q;
  logic      pend_d;
  logic      consume;

  fpe_mode_sel u_mode (
    .ne_bit    (ne_bit),
    .ignore_in (ignore_in),
    .mode      (mode)
  );

  fpe_pending_flag u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .err_event (err_event),
    .err_clear (err_clear),
    .consume   (consume),
    .pend_q    (pend_q),
    .pend_d    (pend_d)
  );

  fpe_report_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .wait_strobe (wait_strobe),
    .pend_q      (pend_q),
    .pend_d      (pend_d),
    .consume     (consume),
    .exc_req     (exc_req),
    .stall       (stall)
  );

  assign err_pin = pend_q && (mode == FPE_EXTERNAL);
endmodule

// File: rtl/fpe_report_chk.sv
module fpe_report_chk (
  input logic clk,
  input logic rst_n,
  input logic ne_bit,
  input logic ignore_in,
  input logic err_event,
  input logic err_clear,
  input logic wait_strobe,
  input logic exc_req,
  input logic err_pin,
  input logic stall
);
  // R4
  exc_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> $past(wait_strobe && ne_bit));

  // R5
  internal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ne_bit |-> !err_pin);

  // R7
  discard_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ne_bit && ignore_in) |-> !err_pin);

  // R9
  stall_from_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall) |-> $past(wait_strobe && !ne_bit && !ignore_in));

  // R10
  stall_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clear && !err_event) |=> !stall);

  // R11
  stall_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ignore_in && !ne_bit) |=> !stall);
endmodule

bind fpe_report_ctrl fpe_report_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ne_bit      (ne_bit),
  .ignore_in   (ignore_in),
  .err_event   (err_event),
  .err_clear   (err_clear),
  .wait_strobe (wait_strobe),
  .exc_req     (exc_req),
  .err_pin     (err_pin),
  .stall       (stall)
);

// File: tb/tb_fpe_report_ctrl.sv
`timescale 1ns/1ps
module tb_fpe_report_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ne_bit = 1'b0, ignore_in = 1'b0, err_event = 1'b0;
  logic err_clear = 1'b0, wait_strobe = 1'b0;
  logic exc_req, err_pin, stall;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [2:0] exp;
    string      tag;
  } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  fpe_report_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ne_bit(ne_bit), .ignore_in(ignore_in),
    .err_event(err_event), .err_clear(err_clear), .wait_strobe(wait_strobe),
    .exc_req(exc_req), .err_pin(err_pin), .stall(stall)
  );

  task automatic compare(input logic [2:0] exp, input string tag);
    logic [2:0] act;
    act = {exc_req, err_pin, stall};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {exc,pin,stall} actual %b expected %b", tag, act, exp);
    end
  endtask

  // driver: apply inputs at negedge, queue the outputs expected after the edge
  task automatic step(input logic ne, ign, ev, clr, ws,
                      input logic [2:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    ne_bit = ne; ignore_in = ign; err_event = ev; err_clear = clr; wait_strobe = ws;
    it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: just after each rising edge, judge the queued expectation
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        compare(it.exp, it.tag);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    err_event = 1'b1; wait_strobe = 1'b1;
    #1 compare(3'b000, "R1 in reset");
    @(negedge clk);
    err_event = 1'b0; wait_strobe = 1'b0; rst_n = 1'b1;
    // bits: {exc_req, err_pin, stall}
    step(0,0,0,0,0, 3'b000, "R1 after reset");
    step(0,0,0,0,1, 3'b000, "R12 strobe no pending");
    step(0,0,1,0,0, 3'b010, "R8 pin on event");
    step(0,0,0,0,0, 3'b010, "R8 pin held");
    step(0,0,0,0,1, 3'b011, "R9 stall on strobe");
    step(0,0,0,0,0, 3'b011, "R9 stall held");
    step(0,0,0,1,0, 3'b000, "R10 clear releases");
    step(0,0,1,1,0, 3'b010, "R3 event beats clear");
    step(0,0,0,0,1, 3'b011, "R9 stall again");
    step(0,1,0,0,0, 3'b000, "R11 ignore releases");
    step(0,0,0,0,0, 3'b000, "R7 pending dropped");
    step(0,1,1,0,1, 3'b000, "R7 event discarded");
    step(0,0,0,0,0, 3'b000, "R7 nothing kept");
    step(1,0,1,0,0, 3'b000, "R5 internal no pin");
    step(1,0,0,0,0, 3'b000, "R5 internal idle");
    step(1,0,0,0,1, 3'b100, "R4 pulse");
    step(1,0,0,0,1, 3'b000, "R4 consumed");
    step(1,1,1,0,0, 3'b000, "R5 ignore irrelevant");
    step(1,0,0,0,1, 3'b100, "R4 pulse after ignore");
    step(1,0,0,0,1, 3'b000, "R6 strobe no pending");
    step(1,0,1,0,1, 3'b000, "R6 strobe before event");
    step(1,0,0,0,1, 3'b100, "R4 pulse late event");
    step(1,0,1,0,0, 3'b000, "R5 set again");
    step(1,0,1,0,1, 3'b100, "R3 event with report");
    step(1,0,0,0,1, 3'b100, "R3 pending retained");
    step(1,0,0,0,0, 3'b000, "R4 single cycle");
    step(1,0,1,0,0, 3'b000, "R5 set for switch");
    step(0,0,0,0,0, 3'b010, "R8 pin after mode switch");
    step(0,0,0,1,0, 3'b000, "R2 clear empties");
    step(0,0,0,0,1, 3'b000, "R2 no stall after clear");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule